// File: doc/BRIEF.md
# PLL Divisor Search Engine

This block takes a requested PLL output frequency in kHz and works out a divisor set for a fixed 24 MHz reference: an input pre-divider NR, a feedback multiplier NF, an output divider NO and, when enabled, an extra post-divider that sits after the PLL. It first derives the output divider, which sets the target VCO frequency. It then walks NR upward one candidate at a time. For each NR it computes the comparison frequency and the nearest usable NF, and it keeps the candidate with the smallest residual error.

A request is loaded with a one-cycle `start`. `busy` stays high while the search runs. The result appears with a one-cycle `done`, and `err` flags a request that could not be met. Every division goes through one shared restoring divider, so a request takes a few thousand cycles. All outputs then hold until the next accepted request.

Top module: `pll_div_search`

## Requirements
- R1: A request with `freq_khz` equal to 0 completes in the next cycle with `done` and `err` high and all divisor outputs zero.
- R2: The starting output divider is ceil(440000 / freq). With `ext_en` high, `ext_o` = ceil(start/16) and the divider becomes ceil(start/`ext_o`). With `ext_en` low, `ext_o` is 1.
- R3: An output divider greater than 1 is rounded up to the next even value. `no_o` is always 1 or even when `err` is low.
- R4: The target VCO is freq x NO x ext. If it lies outside 440000..2200000 kHz, or NO exceeds 16, the request ends with `err` high and zero outputs.
- R5: NR runs from 1 while NR < 64. Fref = floor(24000/NR). A search stops at Fref < 269 and skips Fref > 2200000. NF = floor(VCO/Fref), and the candidate is skipped if NF >= 4096. When the remainder exceeds Fref/2 and NF+1 < 4096, NF is incremented and the error becomes Fref minus the remainder; otherwise the error is the remainder.
- R6: A candidate replaces the kept one only if its error is strictly smaller, so the lowest NR wins a tie. The search ends at once when the kept error is zero, and the kept error starts at the VCO value.
- R7: If the kept error exceeds 4000 kHz at the end, the request ends with `err` high and zero outputs.
- R8: `done` is a one-cycle pulse with `busy` low. `busy` is high from the cycle after an accepted nonzero request until `done`. Outputs change only on the `done` cycle.
- R9: `start` is ignored while `busy` is high. The request in progress completes with its own result.
- R10: After reset, `busy`, `done`, `err` and all divisor outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| freq_khz | input | 22 | Requested output frequency in kHz |
| ext_en | input | 1 | Allow the extra post-divider |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request could not be met |
| nr_o | output | 6 | Chosen pre-divider NR |
| nf_o | output | 13 | Chosen feedback multiplier NF |
| no_o | output | 5 | Chosen output divider NO |
| ext_o | output | 16 | Chosen extra post-divider |

## Verification
The assertions assume that `freq_khz` and `ext_en` are only meaningful in the cycle `start` is accepted. They also assume that `start` may arrive at any time, including while busy. The stimulus changes inputs shortly after a clock edge and holds them through the next edge. It issues a second `start` with a different frequency in the middle of a search. It covers both extra-divider modes, the zero frequency, requests that are too low or too high, and an exact match that ends the search early. A second instance with an out-of-range reference forces the residual-error rejection, which the default reference cannot reach.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NO0, ST_NOX, ST_CHK, ST_FREF, ST_NF, ST_NEXT, ST_END
  } search_st_t;

  // ceil(a / b) for b > 0
  function automatic logic [31:0] f_ceil_div(input logic [31:0] a, input logic [31:0] b);
    return (a + b - 32'd1) / b;
  endfunction

  // output divider: 1 stays 1, anything larger goes to the next even value
  function automatic logic [31:0] f_even_up(input logic [31:0] n);
    return (n > 32'd1) ? ((n + 32'd1) & ~32'd1) : n;
  endfunction

  function automatic logic f_in_range(input logic [63:0] v, input logic [63:0] lo,
                                      input logic [63:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/pll_restdiv.sv
module pll_restdiv #(
  parameter int W = 24,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  logic [W-1:0]  d_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    acc_sh, acc_sub;

  assign acc_sh  = {rem, quot[W-1]};
  assign acc_sub = acc_sh - {1'b0, d_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0; cnt_q <= '0; run_q <= 1'b0; done <= 1'b0;
      quot <= '0; rem <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        quot <= dividend; rem <= '0; d_q <= divisor;
        cnt_q <= CW'(W); run_q <= 1'b1;
      end else if (run_q) begin
        if (!acc_sub[W]) begin
          rem  <= acc_sub[W-1:0];
          quot <= {quot[W-2:0], 1'b1};
        end else begin
          rem  <= acc_sh[W-1:0];
          quot <= {quot[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
  parameter int W        = 24,
  parameter int NF_LIMIT = 4096
) (
  input  logic [W-1:0] fref,
  input  logic [W-1:0] quot,
  input  logic [W-1:0] rem,
  output logic         ok,
  output logic [W-1:0] nf,
  output logic [W-1:0] diff
);
  logic round_up;

  assign ok       = 32'(quot) < NF_LIMIT;
  assign round_up = (rem > (fref >> 1)) && (32'(quot) + 32'd1 < NF_LIMIT);

  always_comb begin
    if (round_up) begin
      nf   = quot + W'(1);
      diff = fref - rem;
    end else begin
      nf   = quot;
      diff = rem;
    end
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int FREQ_W   = 22,
  parameter int REF_KHZ  = 24000,
  parameter int NR_END   = 64,
  parameter int NF_LIMIT = 4096,
  parameter int NO_MAX   = 16,
  parameter int VCO_MIN  = 440000,
  parameter int VCO_MAX  = 2200000,
  parameter int FREF_MIN = 269,
  parameter int FREF_MAX = 2200000,
  parameter int ERR_MAX  = 4000,
  parameter int EXT_W    = 16,
  parameter int DIV_W    = 24,
  localparam int NR_W = $clog2(NR_END),
  localparam int NF_W = $clog2(NF_LIMIT) + 1,
  localparam int NO_W = $clog2(NO_MAX) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] freq_khz,
  input  logic              ext_en,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [NR_W-1:0]   nr_o,
  output logic [NF_W-1:0]   nf_o,
  output logic [NO_W-1:0]   no_o,
  output logic [EXT_W-1:0]  ext_o
);
  localparam int CNT_W = NR_W + 1;

  search_st_t        st;
  logic [FREQ_W-1:0] freq_q;
  logic              ext_en_q, fail_q;
  logic [DIV_W-1:0]  no_w, vco_q, fref_q, best_q, bnf_q;
  logic [EXT_W-1:0]  ext_q;
  logic [CNT_W-1:0]  nr_q, bnr_q;
  logic              dv_go, dv_done;
  logic [DIV_W-1:0]  dv_a, dv_b, dv_q, dv_r;
  logic              ev_ok;
  logic [DIV_W-1:0]  ev_nf, ev_diff;

  // named events for the checker
  logic accept_w, zero_rej_w, cand_take_w;
  assign accept_w    = (st == ST_IDLE) && start;
  assign zero_rej_w  = accept_w && (freq_khz == '0);
  assign cand_take_w = (st == ST_NF) && dv_done && ev_ok && (ev_diff < best_q);
  assign busy        = (st != ST_IDLE);

  // check-stage arithmetic
  logic [31:0] no_even, ext_calc;
  logic [63:0] vco_wide;
  logic        chk_ok;
  assign no_even  = f_even_up(32'(no_w));
  assign ext_calc = f_ceil_div(32'(dv_q), 32'(NO_MAX));
  assign vco_wide = 64'(freq_q) * 64'(no_even) * 64'(ext_q);
  assign chk_ok   = f_in_range(vco_wide, 64'(VCO_MIN), 64'(VCO_MAX)) &&
                    (no_even <= 32'(NO_MAX));

  pll_restdiv #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(dv_go), .dividend(dv_a), .divisor(dv_b),
    .done(dv_done), .quot(dv_q), .rem(dv_r)
  );

  pll_cand_eval #(.W(DIV_W), .NF_LIMIT(NF_LIMIT)) u_eval (
    .fref(fref_q), .quot(dv_q), .rem(dv_r), .ok(ev_ok), .nf(ev_nf), .diff(ev_diff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; freq_q <= '0; ext_en_q <= 1'b0; fail_q <= 1'b0;
      no_w <= '0; vco_q <= '0; fref_q <= '0; best_q <= '0; bnf_q <= '0;
      ext_q <= '0; nr_q <= '0; bnr_q <= '0;
      dv_go <= 1'b0; dv_a <= '0; dv_b <= '0;
      done <= 1'b0; err <= 1'b0;
      nr_o <= '0; nf_o <= '0; no_o <= '0; ext_o <= '0;
    end else begin
      dv_go <= 1'b0;
      done  <= 1'b0;
      unique case (st)
        ST_IDLE: if (zero_rej_w) begin
          done <= 1'b1; err <= 1'b1;
          nr_o <= '0; nf_o <= '0; no_o <= '0; ext_o <= '0;
        end else if (accept_w) begin
          freq_q <= freq_khz; ext_en_q <= ext_en; fail_q <= 1'b0;
          dv_go <= 1'b1;
          dv_a  <= DIV_W'(VCO_MIN) + DIV_W'(freq_khz) - DIV_W'(1);
          dv_b  <= DIV_W'(freq_khz);
          st    <= ST_NO0;
        end
        ST_NO0: if (dv_done) begin
          if (ext_en_q) begin
            ext_q <= EXT_W'(ext_calc);
            dv_go <= 1'b1;
            dv_a  <= dv_q + DIV_W'(ext_calc) - DIV_W'(1);
            dv_b  <= DIV_W'(ext_calc);
            st    <= ST_NOX;
          end else begin
            ext_q <= EXT_W'(1); no_w <= dv_q; st <= ST_CHK;
          end
        end
        ST_NOX: if (dv_done) begin
          no_w <= dv_q; st <= ST_CHK;
        end
        ST_CHK: begin
          no_w <= DIV_W'(no_even);
          if (!chk_ok) begin
            fail_q <= 1'b1; st <= ST_END;
          end else begin
            vco_q  <= DIV_W'(vco_wide);
            best_q <= DIV_W'(vco_wide);
            bnr_q  <= '0; bnf_q <= '0;
            nr_q   <= CNT_W'(1);
            dv_go  <= 1'b1; dv_a <= DIV_W'(REF_KHZ); dv_b <= DIV_W'(1);
            st     <= ST_FREF;
          end
        end
        ST_FREF: if (dv_done) begin
          fref_q <= dv_q;
          if (32'(dv_q) < FREF_MIN) st <= ST_END;
          else if (32'(dv_q) > FREF_MAX) st <= ST_NEXT;
          else begin
            dv_go <= 1'b1; dv_a <= vco_q; dv_b <= dv_q; st <= ST_NF;
          end
        end
        ST_NF: if (dv_done) begin
          if (cand_take_w) begin
            best_q <= ev_diff; bnr_q <= nr_q; bnf_q <= ev_nf;
          end
          st <= ST_NEXT;
        end
        ST_NEXT: begin
          if ((32'(nr_q) + 32'd1 >= NR_END) || (best_q == '0)) st <= ST_END;
          else begin
            nr_q  <= nr_q + CNT_W'(1);
            dv_go <= 1'b1; dv_a <= DIV_W'(REF_KHZ); dv_b <= DIV_W'(nr_q) + DIV_W'(1);
            st    <= ST_FREF;
          end
        end
        ST_END: begin
          done <= 1'b1;
          st   <= ST_IDLE;
          if (fail_q || (32'(best_q) > ERR_MAX)) begin
            err <= 1'b1; nr_o <= '0; nf_o <= '0; no_o <= '0; ext_o <= '0;
          end else begin
            err  <= 1'b0;
            nr_o <= NR_W'(bnr_q); nf_o <= NF_W'(bnf_q);
            no_o <= NO_W'(no_w);  ext_o <= ext_q;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int FREQ_W = 22,
  parameter int NR_END = 64,
  parameter int NO_MAX = 16,
  parameter int NR_W   = 6,
  parameter int NF_W   = 13,
  parameter int NO_W   = 5,
  parameter int EXT_W  = 16,
  parameter int DIV_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [NR_W-1:0]   nr_o,
  input logic [NF_W-1:0]   nf_o,
  input logic [NO_W-1:0]   no_o,
  input logic [EXT_W-1:0]  ext_o,
  input logic [FREQ_W-1:0] freq_q,
  input logic [DIV_W-1:0]  best_q,
  input logic              zero_rej_w,
  input logic              cand_take_w
);
  AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    zero_rej_w |=> (done && err && nr_o == '0 && no_o == '0)); // R1
  AST_NO_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (no_o == NO_W'(1) || !no_o[0])); // R3
  AST_NO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (no_o != '0 && 32'(no_o) <= NO_MAX)); // R4
  AST_NR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (nr_o != '0 && 32'(nr_o) < NR_END)); // R5
  AST_BEST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cand_take_w |=> (best_q < $past(best_q))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !zero_rej_w) |=> ($stable(nr_o) && $stable(nf_o) && $stable(no_o) &&
                                $stable(ext_o) && $stable(err))); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(freq_q)); // R9
endmodule

bind pll_div_search pll_div_search_chk #(
  .FREQ_W(FREQ_W), .NR_END(NR_END), .NO_MAX(NO_MAX), .NR_W(NR_W), .NF_W(NF_W),
  .NO_W(NO_W), .EXT_W(EXT_W), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .nr_o(nr_o), .nf_o(nf_o), .no_o(no_o), .ext_o(ext_o),
  .freq_q(freq_q), .best_q(best_q), .zero_rej_w(zero_rej_w), .cand_take_w(cand_take_w)
);

// File: tb/tb_pll_div_search.sv
`timescale 1ns/1ps
module tb_pll_div_search;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ext_en = 1'b0;
  logic [21:0] freq = '0;
  logic busy, done, err;
  logic [5:0] nr; logic [12:0] nf; logic [4:0] no; logic [15:0] ext;

  logic start2 = 1'b0;
  logic [21:0] freq2 = '0;
  logic busy2, done2, err2;
  logic [0:0] nr2; logic [12:0] nf2; logic [4:0] no2; logic [15:0] ext2;

  always #5 clk = ~clk;

  pll_div_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_khz(freq), .ext_en(ext_en),
    .busy(busy), .done(done), .err(err), .nr_o(nr), .nf_o(nf), .no_o(no), .ext_o(ext)
  );

  // reference that the default cannot reach the error limit with
  pll_div_search #(.REF_KHZ(2000000), .NR_END(2)) dut2 (
    .clk(clk), .rst_n(rst_n), .start(start2), .freq_khz(freq2), .ext_en(1'b0),
    .busy(busy2), .done(done2), .err(err2), .nr_o(nr2), .nf_o(nf2), .no_o(no2), .ext_o(ext2)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference of the search
  task automatic model(input longint f, input bit en, input longint rk, input int nrend,
                       output longint r_nr, output longint r_nf, output longint r_no,
                       output longint r_ext, output longint r_err);
    longint n, e, vco, best, fref, nfv, d, bnf;
    int bnr;
    r_nr = 0; r_nf = 0; r_no = 0; r_ext = 0; r_err = 1;
    bnr = 0; bnf = 0;
    if (f == 0) return;
    n = (440000 + f - 1) / f;
    e = 1;
    if (en) begin e = (n + 15) / 16; n = (n + e - 1) / e; end
    if (n > 1) n = ((n + 1) / 2) * 2;
    vco = f * n * e;
    if (vco < 440000 || vco > 2200000 || n > 16) return;
    best = vco;
    for (int k = 1; k < nrend && best != 0; k++) begin
      fref = rk / k;
      if (fref < 269) break;
      if (fref > 2200000) continue;
      nfv = vco / fref;
      if (nfv >= 4096) continue;
      d = vco - nfv * fref;
      if (nfv + 1 < 4096 && d > fref / 2) begin nfv++; d = fref - d; end
      if (d < best) begin best = d; bnr = k; bnf = nfv; end
    end
    if (best > 4000) return;
    r_nr = bnr; r_nf = bnf; r_no = n; r_ext = e; r_err = 0;
  endtask

  // cycle-by-cycle model: 0 idle, 1 searching, 2 zero request pending
  int mode = 0;
  string cur_tag = "R2", idle_tag = "R10";
  longint e_nr, e_nf, e_no, e_ext, e_err;
  longint h_nr = 0, h_nf = 0, h_no = 0, h_ext = 0, h_err = 0;

  task automatic cmp_outs(input string tag, input longint a, input longint b,
                          input longint c, input longint d, input longint e);
    chk(tag, "nr", longint'(nr), a);
    chk(tag, "nf", longint'(nf), b);
    chk(tag, "no", longint'(no), c);
    chk(tag, "ext", longint'(ext), d);
    chk(tag, "err", longint'(err), e);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      case (mode)
        0: begin
          chk(idle_tag, "busy", longint'(busy), 0);
          chk(idle_tag, "done", longint'(done), 0);
          cmp_outs(idle_tag, h_nr, h_nf, h_no, h_ext, h_err);
        end
        2: begin
          chk("R1", "done", longint'(done), 1);
          chk("R1", "busy", longint'(busy), 0);
          h_nr = 0; h_nf = 0; h_no = 0; h_ext = 0; h_err = 1;
          cmp_outs("R1", h_nr, h_nf, h_no, h_ext, h_err);
          mode = 0;
        end
        default: begin
          if (done) begin
            chk("R8", "busy at done", longint'(busy), 0);
            cmp_outs(cur_tag, e_nr, e_nf, e_no, e_ext, e_err);
            h_nr = e_nr; h_nf = e_nf; h_no = e_no; h_ext = e_ext; h_err = e_err;
            idle_tag = "R8";
            mode = 0;
          end else begin
            chk("R8", "busy in search", longint'(busy), 1);
            cmp_outs("R8", h_nr, h_nf, h_no, h_ext, h_err);
          end
        end
      endcase
      // next-cycle expectation from the inputs the next edge will sample
      if (mode == 0 && start) begin
        if (freq == 0) mode = 2;
        else begin
          model(longint'(freq), ext_en, 24000, 64, e_nr, e_nf, e_no, e_ext, e_err);
          mode = 1;
        end
      end
    end
  end

  task automatic request(input int f, input bit en, input string tag);
    @(posedge clk); #2;
    start = 1'b1; freq = 22'(f); ext_en = en; cur_tag = tag;
    @(posedge clk); #2;
    start = 1'b0;
    do @(negedge clk); while (!done && !finished);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);           // reset state checked while idle, R10
    request(0, 1'b0, "R1");              // zero request
    request(148500, 1'b1, "R5");         // nearest-NF search
    request(65000, 1'b0, "R6");          // best-of-candidates
    request(27000, 1'b1, "R2");          // extra divider engaged
    request(1, 1'b1, "R2");              // very large extra divider
    request(150000, 1'b0, "R3");         // odd start divider rounded to even
    request(1000, 1'b0, "R4");           // NO above limit
    request(3000000, 1'b0, "R4");        // VCO above limit
    request(600000, 1'b0, "R6");         // exact match ends search early
    // R9: second start with another frequency while busy
    @(posedge clk); #2;
    start = 1'b1; freq = 22'd74250; ext_en = 1'b1; cur_tag = "R9";
    @(posedge clk); #2;
    start = 1'b0;
    repeat (7) @(posedge clk); #2;
    start = 1'b1; freq = 22'd200000; ext_en = 1'b0;
    @(posedge clk); #2;
    start = 1'b0; freq = 22'd0;
    do @(negedge clk); while (!done && !finished);
    repeat (3) @(posedge clk);
    // R7: residual error above the limit on the second instance
    begin
      longint a, b, c, d, e;
      model(100000, 1'b0, 2000000, 2, a, b, c, d, e);
      @(posedge clk); #2;
      start2 = 1'b1; freq2 = 22'd100000;
      @(posedge clk); #2;
      start2 = 1'b0;
      do @(negedge clk); while (!done2 && !finished);
      chk("R7", "err", longint'(err2), e);
      chk("R7", "no", longint'(no2), c);
      chk("R7", "nf", longint'(nf2), b);
    end
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule